// File: doc/BRIEF.md
# Five-Level Current Inverter Gate Sequencer

This block drives the eight gate levels of a five-level current source inverter over one modulation period. There are six bridge switches (bits 0 to 5 for switches 1 to 6) and two shunt bypass switches (bit 6 for shunt A, bit 7 for shunt B). Each period is described by a descriptor of `NSEG` segments. Every segment carries a vector kind, a bridge vector number and an end tick.

A free-running tick counter walks through the period. The descriptor offered on the inputs is taken at the period boundary, and only if it passes a set of legality checks. If it fails, the previous descriptor runs again.

Every change of the gate word goes through a one-cycle safe state with both shunts on and the bridge off. A current path therefore stays open at all times, and every change of the bridge pair happens while the shunts carry the current.

Top module: `csi_gate_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `gate` is 0xC0 (both shunts on, bridge off) and `period_start` is 0. Until a legal descriptor is loaded, `gate` stays 0xC0.
- R2: A large segment (kind 2) with vector k turns on two bridge bits and no shunt. The bits are k=1:{0,1}, k=2:{1,2}, k=3:{2,3}, k=4:{3,4}, k=5:{4,5}, k=6:{0,5}.
- R3: A small segment (kind 1) turns on the same bridge pair as the large vector with the same number, plus one shunt. It uses shunt A (bit 6) while the tick is below PERIOD/2 and shunt B (bit 7) from PERIOD/2 on.
- R4: A zero segment (kind 0) gives 0xC0.
- R5: Segment i covers ticks from the previous segment's end tick (0 for segment 0) up to, but not including, its own end tick. The last segment also covers any ticks beyond its end. The gate word for tick t is computed during tick t and appears during tick t+1. When that word differs from the word on the outputs, and the outputs are not 0xC0, the outputs first show 0xC0 for one cycle.
- R6: The gate word is never 0. It always shows either exactly two bridge bits with at most one shunt, or no bridge bit with both shunts.
- R7: `desc_ready` is high in the last tick of the period, and the descriptor is taken only at that edge. `period_start` is high in the following cycle, which is tick 0. A descriptor changed in the middle of a period does not affect that period.
- R8: A descriptor whose end ticks are not strictly ascending, or where any end tick exceeds PERIOD, is rejected. The previous descriptor is repeated.
- R9: A descriptor is also rejected if it contains any of the following, and the previous descriptor is repeated:
  - kind 3;
  - a small or large segment whose vector is outside 1..6;
  - two adjacent large segments with different vectors.
- R10: For a descriptor whose shunt pattern in the second half mirrors the first half, shunt A and shunt B are on for the same number of ticks over the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | A descriptor is offered |
| desc_kind | input | 2*NSEG | Kind of each segment, segment 0 in the low bits |
| desc_vec | input | 3*NSEG | Bridge vector number 1..6 of each segment |
| desc_end | input | TW*NSEG | End tick of each segment |
| desc_ready | output | 1 | Last tick of the period; the descriptor is taken at this edge |
| period_start | output | 1 | High during tick 0 |
| gate | output | 8 | Gate levels: bits 0..5 bridge switches 1..6, bit 6 shunt A, bit 7 shunt B |

## Verification
The bench builds the block with PERIOD=40 and NSEG=4. This puts a whole period within 40 cycles, so every tick of several periods is compared against an independent model. It also places the half-period shunt handover at tick 20, where it is easy to reach. Four segments are enough to cover all six bridge pairs, small-to-small pair changes, mirrored shunt patterns, and each rejection rule.

// File: rtl/csi_gate_seq.sv
module csi_gate_seq #(
  parameter int PERIOD = 40000,
  parameter int NSEG = 8,
  localparam int TW = $clog2(PERIOD + 1),
  localparam int SW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                desc_valid,
  input  logic [2*NSEG-1:0]   desc_kind,
  input  logic [3*NSEG-1:0]   desc_vec,
  input  logic [TW*NSEG-1:0]  desc_end,
  output logic                desc_ready,
  output logic                period_start,
  output logic [7:0]          gate
);
  localparam logic [7:0] SAFE = 8'hC0;

  logic [TW-1:0]      tick;
  logic [2*NSEG-1:0]  act_kind;
  logic [3*NSEG-1:0]  act_vec;
  logic [TW*NSEG-1:0] act_end;
  logic               desc_ok;
  logic [SW-1:0]      sel;
  logic [7:0]         target;

  function automatic logic [5:0] bridge_pair(input logic [2:0] v);
    case (v)
      3'd1: bridge_pair = 6'b000011;
      3'd2: bridge_pair = 6'b000110;
      3'd3: bridge_pair = 6'b001100;
      3'd4: bridge_pair = 6'b011000;
      3'd5: bridge_pair = 6'b110000;
      3'd6: bridge_pair = 6'b100001;
      default: bridge_pair = 6'b000000;
    endcase
  endfunction

  assign desc_ready = (tick == TW'(PERIOD - 1));

  always_comb begin : legality
    logic [1:0]    k;
    logic [2:0]    v;
    logic [TW-1:0] e;
    desc_ok = 1'b1;
    for (int i = 0; i < NSEG; i++) begin
      k = desc_kind[2*i +: 2];
      v = desc_vec[3*i +: 3];
      e = desc_end[TW*i +: TW];
      if (k == 2'd3) desc_ok = 1'b0;
      if (k != 2'd0 && (v == 3'd0 || v > 3'd6)) desc_ok = 1'b0;
      if (e > TW'(PERIOD)) desc_ok = 1'b0;
      if (i > 0) begin
        if (e <= desc_end[TW*(i-1) +: TW]) desc_ok = 1'b0;
        if (k == 2'd2 && desc_kind[2*(i-1) +: 2] == 2'd2 && v != desc_vec[3*(i-1) +: 3])
          desc_ok = 1'b0;
      end
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NSEG - 1; i++)
      if (tick >= act_end[TW*i +: TW]) sel = SW'(i + 1);
  end

  always_comb begin
    case (act_kind[2*sel +: 2])
      2'd1: target = {(tick >= TW'(PERIOD/2)), (tick < TW'(PERIOD/2)),
                      bridge_pair(act_vec[3*sel +: 3])};
      2'd2: target = {2'b00, bridge_pair(act_vec[3*sel +: 3])};
      default: target = SAFE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= '0;
      act_kind <= '0;
      act_vec <= '0;
      act_end <= '0;
      period_start <= 1'b0;
      gate <= SAFE;
    end else begin
      tick <= desc_ready ? '0 : tick + 1'b1;
      period_start <= desc_ready;
      if (desc_ready && desc_valid && desc_ok) begin
        act_kind <= desc_kind;
        act_vec <= desc_vec;
        act_end <= desc_end;
      end
      if (target != gate) gate <= (gate == SAFE) ? target : SAFE;
    end
  end
endmodule

module csi_gate_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       desc_ready,
  input logic       period_start,
  input logic [7:0] gate
);
  assert_never_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gate != 8'h00);

  assert_legal_combo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gate[5:0]) == 0 && gate[7:6] == 2'b11) ||
    ($countones(gate[5:0]) == 2 && gate[7:6] != 2'b11));

  assert_safe_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate != $past(gate) && $past(gate) != 8'hC0) |-> gate == 8'hC0);

  assert_bridge_under_shunt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate[5:0] != $past(gate[5:0])) |-> ($past(gate[7:6]) != 2'b00 || gate[7:6] != 2'b00));

  assert_start_follows_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |=> period_start);

  assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);
endmodule

bind csi_gate_seq csi_gate_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .desc_ready(desc_ready),
  .period_start(period_start), .gate(gate)
);

// File: tb/csi_gate_seq_test.sv
module csi_gate_seq_test;
  localparam int P = 40;
  localparam int NS = 4;
  localparam int TW = $clog2(P + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic desc_valid = 1'b0;
  logic [2*NS-1:0]  dk = '0;
  logic [3*NS-1:0]  dv = '0;
  logic [TW*NS-1:0] de = '0;
  logic desc_ready, period_start;
  logic [7:0] gate;

  int checks = 0;
  int errors = 0;
  logic [7:0] cap  [0:P-1];
  logic [7:0] expg [0:P-1];

  always #2.5 clk = ~clk;

  csi_gate_seq #(.PERIOD(P), .NSEG(NS)) uut (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_kind(dk),
    .desc_vec(dv), .desc_end(de), .desc_ready(desc_ready),
    .period_start(period_start), .gate(gate));

  task automatic chk(input logic ok, input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic logic [5:0] pairbits(input int v);
    case (v)
      1: return 6'b000011; 2: return 6'b000110; 3: return 6'b001100;
      4: return 6'b011000; 5: return 6'b110000; 6: return 6'b100001;
      default: return 6'b0;
    endcase
  endfunction

  function automatic logic [7:0] tgt(input logic [2*NS-1:0] k, input logic [3*NS-1:0] v,
                                     input logic [TW*NS-1:0] e, input int t);
    int s = 0;
    for (int i = 0; i < NS - 1; i++) if (t >= int'(e[TW*i +: TW])) s = i + 1;
    case (k[2*s +: 2])
      2'd1: return {(t >= P/2), (t < P/2), pairbits(int'(v[3*s +: 3]))};
      2'd2: return {2'b00, pairbits(int'(v[3*s +: 3]))};
      default: return 8'hC0;
    endcase
  endfunction

  function automatic logic [7:0] step(input logic [7:0] g, input logic [7:0] x);
    if (x == g) return g;
    if (g == 8'hC0) return x;
    return 8'hC0;
  endfunction

  task automatic model(input logic [2*NS-1:0] pk, input logic [3*NS-1:0] pv, input logic [TW*NS-1:0] pe,
                       input logic [2*NS-1:0] ck, input logic [3*NS-1:0] cv, input logic [TW*NS-1:0] ce);
    logic [7:0] g = 8'hC0;
    for (int t = 0; t < P; t++) g = step(g, tgt(pk, pv, pe, t));
    expg[0] = g;
    for (int t = 1; t < P; t++) begin
      g = step(g, tgt(ck, cv, ce, t - 1));
      expg[t] = g;
    end
  endtask

  task automatic next_ps();
    @(negedge clk);
    while (!period_start) @(negedge clk);
  endtask

  task automatic capture(input int from);
    for (int t = from; t < P; t++) begin
      cap[t] = gate;
      @(negedge clk);
    end
  endtask

  task automatic compare(input int from, input string tag);
    logic dark = 1'b0;
    for (int t = from; t < P; t++) begin
      chk(cap[t] == expg[t], tag, cap[t], expg[t]);
      if (cap[t] == 8'h00) dark = 1'b1;
    end
    chk(!dark, "R6 never all off", 8'h00, 8'hC0);
  endtask

  task automatic load_and_capture(input logic [2*NS-1:0] k, input logic [3*NS-1:0] v, input logic [TW*NS-1:0] e);
    dk = k; dv = v; de = e; desc_valid = 1'b1;
    next_ps();
    next_ps();
    capture(0);
  endtask

  localparam logic [2*NS-1:0]  KA = {2'd0, 2'd1, 2'd2, 2'd1};
  localparam logic [3*NS-1:0]  VA = {3'd0, 3'd1, 3'd1, 3'd1};
  localparam logic [2*NS-1:0]  KB = {2'd0, 2'd1, 2'd0, 2'd1};
  localparam logic [3*NS-1:0]  VB = {3'd0, 3'd1, 3'd0, 3'd1};
  localparam logic [2*NS-1:0]  KC = {2'd2, 2'd0, 2'd1, 2'd2};
  localparam logic [3*NS-1:0]  VC = {3'd4, 3'd0, 3'd6, 3'd6};
  localparam logic [2*NS-1:0]  KD = {2'd2, 2'd1, 2'd1, 2'd2};
  localparam logic [3*NS-1:0]  VD = {3'd5, 3'd3, 3'd2, 3'd2};
  localparam logic [TW*NS-1:0] EN = {6'd40, 6'd30, 6'd20, 6'd10};

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(gate == 8'hC0, "R1 gate in reset", gate, 8'hC0);
    chk(period_start == 1'b0, "R1 strobe in reset", {7'd0, period_start}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gate == 8'hC0, "R1 gate after reset", gate, 8'hC0);
    chk(period_start == 1'b0, "R1 strobe after reset", {7'd0, period_start}, 8'h00);
    next_ps();
    capture(0);
    model(KB, VB, EN, KB, VB, EN);
    for (int t = 0; t < P; t++) expg[t] = 8'hC0;
    compare(0, "R1 idle zero vector");
  endtask

  task automatic test_mixed();
    load_and_capture(KA, VA, EN);
    model(KA, VA, EN, KA, VA, EN);
    compare(0, "R5 mixed period");
    chk(cap[1] == 8'h43, "R3 small first half", cap[1], 8'h43);
    chk(cap[11] == 8'hC0, "R5 safe cycle", cap[11], 8'hC0);
    chk(cap[12] == 8'h03, "R2 large pair 1", cap[12], 8'h03);
    chk(cap[21] == 8'hC0, "R5 safe cycle", cap[21], 8'hC0);
    chk(cap[22] == 8'h83, "R3 small second half", cap[22], 8'h83);
    chk(cap[35] == 8'hC0, "R4 zero vector", cap[35], 8'hC0);
  endtask

  task automatic test_pairs();
    load_and_capture(KC, VC, EN);
    model(KC, VC, EN, KC, VC, EN);
    compare(0, "R2 pairs C");
    chk(cap[0] == 8'h18, "R2 large pair 4", cap[0], 8'h18);
    chk(cap[1] == 8'hC0, "R5 safe at wrap", cap[1], 8'hC0);
    chk(cap[5] == 8'h21, "R2 large pair 6", cap[5], 8'h21);
    chk(cap[15] == 8'h61, "R3 small vector 6", cap[15], 8'h61);
    chk(cap[25] == 8'hC0, "R4 zero vector", cap[25], 8'hC0);
    load_and_capture(KD, VD, EN);
    model(KD, VD, EN, KD, VD, EN);
    compare(0, "R2 pairs D");
    chk(cap[5] == 8'h06, "R2 large pair 2", cap[5], 8'h06);
    chk(cap[15] == 8'h46, "R3 small vector 2", cap[15], 8'h46);
    chk(cap[25] == 8'h8C, "R3 small vector 3", cap[25], 8'h8C);
    chk(cap[35] == 8'h30, "R2 large pair 5", cap[35], 8'h30);
  endtask

  task automatic test_symmetry();
    int a = 0;
    int b = 0;
    load_and_capture(KB, VB, EN);
    model(KB, VB, EN, KB, VB, EN);
    compare(0, "R10 mirrored period");
    for (int t = 0; t < P; t++) begin
      a += int'(cap[t][6]);
      b += int'(cap[t][7]);
    end
    chk(a == b && a == 30, "R10 equal shunt time", 8'(a), 8'(b));
  endtask

  task automatic test_midload();
    load_and_capture(KA, VA, EN);
    capture(0);
    cap[0] = gate;
    @(negedge clk);
    cap[1] = gate;
    @(negedge clk);
    dk = KB; dv = VB;
    capture(2);
    model(KA, VA, EN, KA, VA, EN);
    compare(0, "R7 no mid-period effect");
    chk(period_start == 1'b1, "R7 strobe at tick 0", {7'd0, period_start}, 8'h01);
    capture(0);
    model(KA, VA, EN, KB, VB, EN);
    compare(0, "R7 taken at boundary");
  endtask

  task automatic test_reject(input logic [2*NS-1:0] k, input logic [3*NS-1:0] v,
                             input logic [TW*NS-1:0] e, input string tag);
    load_and_capture(KC, VC, EN);
    load_and_capture(k, v, e);
    model(KC, VC, EN, KC, VC, EN);
    compare(0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_mixed();
    test_pairs();
    test_symmetry();
    test_midload();
    test_reject(KA, VA, {6'd40, 6'd30, 6'd5, 6'd10}, "R8 descending ends");
    test_reject(KA, VA, {6'd41, 6'd30, 6'd20, 6'd10}, "R8 end over period");
    test_reject({2'd0, 2'd1, 2'd3, 2'd1}, VA, EN, "R9 kind 3");
    test_reject(KA, {3'd0, 3'd1, 3'd1, 3'd7}, EN, "R9 vector out of range");
    test_reject({2'd0, 2'd0, 2'd2, 2'd2}, {3'd0, 3'd0, 3'd2, 3'd1}, EN, "R9 large to large");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule